// File: doc/BRIEF.md
# Slow Clock Calibration Counter

The block measures how long a slow clock period is, in units of a fast reference clock. Software picks one of three slow sources, a window length in slow cycles and an optional timeout limit. The block then counts reference cycles from one rising edge of the chosen source until the programmed number of further rising edges has passed, and reports that count. One of the sources is a fast RC oscillator. That source first passes through a fixed divide-by-32 prescaler, so each of its window cycles lasts 32 oscillator cycles.

Two start controls exist. A rising level on the one-shot control runs a single window and then raises a ready flag. A high level on the continuous control runs windows back to back. Each completed window replaces the result in one step, and the next window starts counting on the same edge. In continuous mode, a new window length takes effect from the next window with no restart. The selected slow clock and both start controls cross into the reference domain through two-flop synchronisers. The window length, source select and threshold are expected to be quasi-static and are captured when a measurement is armed.

A nonzero timeout limit ends a measurement whose reference-cycle age reaches the limit before the window closes. Requests that can never complete are rejected at once through the same timeout flag. These are a zero window, a window at or above the field maximum, and an unused source code.

Top module: `slow_cal_counter`

## Requirements
- R1: With source code 0 (slow RC) or 2 (32 kHz crystal), a completed window reports exactly N times the source period in reference cycles, where N is the window field.
- R2: With source code 1 (fast RC), the oscillator is divided by 32 before counting, so the result is N × 32 × the oscillator period in reference cycles.
- R3: While the continuous control is low, a rising edge on the one-shot control runs exactly one window. At its end, ready goes high and the result is held.
- R4: Each one-shot start clears ready, timeout and the result before the new window counts.
- R5: In continuous mode, windows repeat with no further control activity. The result is replaced at each window end, and a changed window length is used from the next window onward.
- R6: If the continuous control is held high through reset, measurements begin after reset with no start edge.
- R7: When the reference-cycle age of a measurement, counted from arming, reaches a nonzero timeout limit before the window closes, timeout goes high. A one-shot measurement then ends without ready. A limit of 0 disables the timeout.
- R8: A request with window 0, with window ≥ 32767 (field all ones), or with source code 3 raises timeout at once and never raises ready.
- R9: In continuous mode, a timeout re-arms the measurement and re-reads the limit. The next completed window sets ready and clears timeout.
- R10: The result changes only at a window end or at a one-shot start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all counting runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_slow_rc | input | 1 | Slow RC source (code 0) |
| clk_fast_rc | input | 1 | Fast RC source, divided by 32 internally (code 1) |
| clk_xtal32k | input | 1 | 32 kHz crystal source (code 2) |
| src_sel | input | 2 | Source select code |
| win_cycles | input | 15 | Window length in slow cycles |
| tmo_limit | input | 25 | Timeout limit in reference cycles, 0 disables |
| start_once | input | 1 | One-shot start, acts on its rising level |
| start_cont | input | 1 | Continuous mode enable |
| ready | output | 1 | Window completed |
| timeout | output | 1 | Measurement aborted or request rejected |
| ref_count | output | 25 | Reference cycles counted in the last window |

## Verification
The bench generates every slow source as an exact multiple of the reference period, so each window has a single correct count. A window that starts on the wrong edge or closes one edge late shows up as an off-by-one-period result. A design that skipped the prescaler would report a fast-RC result 32 times too small. The bench changes the source between runs, which exposes a mux-switch glitch taken as a window start. It changes the window length in the middle of a continuous run, where a design that latched the length only once would keep the old value. Tight limits, a zero limit and illegal requests show whether timeout is missed, raised by a disabled limit, or whether a rejected request hangs with neither flag set. After a continuous-mode timeout, the bench checks that ready returns and timeout drops.

// File: rtl/slow_cal_pkg.sv
package slow_cal_pkg;

  typedef enum logic [1:0] {
    SRC_SLOW_RC = 2'd0,
    SRC_FAST_RC = 2'd1,
    SRC_XTAL32K = 2'd2
  } cal_src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_COUNT = 2'd2
  } win_state_e;

  // A request is usable when the source code exists and the window length
  // is nonzero and below the all-ones field value.
  function automatic logic request_ok(input logic [1:0] sel,
                                      input int unsigned cnt,
                                      input int unsigned cnt_limit);
    return (sel <= SRC_XTAL32K) && (cnt != 0) && (cnt < cnt_limit);
  endfunction

  // Next age value and the "limit reached" test, kept together so the
  // comparison rule lives in one place.
  function automatic logic limit_hit(input int unsigned age_next,
                                     input int unsigned limit);
    return (limit != 0) && (age_next == limit);
  endfunction

endpackage

// File: rtl/cal_sync_2ff.sv
module cal_sync_2ff #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[g] <= '0;
      else        stage[g] <= stage[g-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
  parameter int DIV_LOG2 = 5
) (
  input  logic src_clk,
  input  logic rst_n,
  output logic div_clk
);
  logic [DIV_LOG2-1:0] div_cnt;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= div_cnt + DIV_LOG2'(1);
  end

  // MSB toggles every 2**(DIV_LOG2-1) input cycles: period 2**DIV_LOG2.
  assign div_clk = div_cnt[DIV_LOG2-1];
endmodule

// File: rtl/cal_source_select.sv
module cal_source_select
  import slow_cal_pkg::*;
#(
  parameter int DIV_LOG2    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic       clk_slow_rc,
  input  logic       clk_fast_rc,
  input  logic       clk_xtal32k,
  output logic       slow_rise
);
  logic fast_div;
  logic mux_out;
  logic synced;
  logic synced_q;

  cal_prescaler #(.DIV_LOG2(DIV_LOG2)) i_prescaler (
    .src_clk (clk_fast_rc),
    .rst_n   (rst_n),
    .div_clk (fast_div)
  );

  always_comb begin
    case (sel)
      SRC_SLOW_RC: mux_out = clk_slow_rc;
      SRC_FAST_RC: mux_out = fast_div;
      SRC_XTAL32K: mux_out = clk_xtal32k;
      default:     mux_out = 1'b0;
    endcase
  end

  cal_sync_2ff #(.W(1), .STAGES(SYNC_STAGES)) i_clk_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (mux_out),
    .q     (synced)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) synced_q <= 1'b0;
    else        synced_q <= synced;
  end

  assign slow_rise = synced & ~synced_q;
endmodule

// File: rtl/cal_window_ctrl.sv
module cal_window_ctrl
  import slow_cal_pkg::*;
#(
  parameter int CNT_W       = 15,
  parameter int RES_W       = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_pulse,
  input  logic             cont_mode,
  input  logic             slow_rise,
  input  logic [1:0]       sel_in,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic [RES_W-1:0] thr_in,
  output logic [1:0]       sel_act,
  output logic             ready,
  output logic             timeout,
  output logic [RES_W-1:0] result,
  output logic             ev_done,
  output logic             ev_timeout,
  output logic             ev_clear
);
  localparam int unsigned CNT_LIMIT = (1 << CNT_W) - 1;
  localparam logic [RES_W-1:0] SETTLE = RES_W'(SYNC_STAGES);

  win_state_e       state;
  logic             run_cont;
  logic [1:0]       sel_lat;
  logic [CNT_W-1:0] cnt_lat;
  logic [RES_W-1:0] thr_lat;
  logic [CNT_W-1:0] edges;
  logic [RES_W-1:0] res_cnt;
  logic [RES_W-1:0] age;
  logic [RES_W-1:0] age_nxt;

  logic busy, oneshot_go, cont_go, start_req, req_ok;
  logic accept, reject, abort, last_edge, expire, settled;

  assign busy       = (state != ST_IDLE);
  assign oneshot_go = arm_pulse && !cont_mode;
  assign cont_go    = cont_mode && (state == ST_IDLE);
  assign start_req  = oneshot_go || cont_go;
  assign req_ok     = request_ok(sel_in, 32'(cnt_in), CNT_LIMIT);
  assign accept     = start_req && req_ok;
  assign reject     = start_req && !req_ok;
  assign abort      = !start_req && busy && run_cont && !cont_mode;
  assign age_nxt    = age + RES_W'(1);
  // Ignore edges produced by the source mux switching while the new
  // selection travels through the synchroniser.
  assign settled    = (age > SETTLE);
  assign last_edge  = (state == ST_COUNT) && slow_rise &&
                      ((edges + CNT_W'(1)) == cnt_lat);

  assign ev_clear   = oneshot_go;
  assign ev_done    = !start_req && !abort && last_edge;
  assign expire     = !start_req && !abort && busy && !last_edge &&
                      limit_hit(32'(age_nxt), 32'(thr_lat));
  assign ev_timeout = reject || expire;
  assign sel_act    = sel_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      run_cont <= 1'b0;
      sel_lat  <= '0;
      cnt_lat  <= '0;
      thr_lat  <= '0;
      edges    <= '0;
      res_cnt  <= '0;
      age      <= '0;
    end else if (accept) begin
      state    <= ST_ARM;
      run_cont <= cont_mode;
      sel_lat  <= sel_in;
      cnt_lat  <= cnt_in;
      thr_lat  <= thr_in;
      age      <= '0;
    end else if (reject || abort) begin
      state <= ST_IDLE;
    end else if (ev_done) begin
      age     <= '0;
      res_cnt <= '0;
      edges   <= '0;
      if (run_cont) begin
        state   <= ST_COUNT;
        thr_lat <= thr_in;
        if (request_ok(sel_lat, 32'(cnt_in), CNT_LIMIT)) cnt_lat <= cnt_in;
      end else begin
        state <= ST_IDLE;
      end
    end else if (expire) begin
      age     <= '0;
      thr_lat <= thr_in;
      state   <= run_cont ? ST_ARM : ST_IDLE;
    end else begin
      case (state)
        ST_ARM: begin
          age <= age_nxt;
          if (slow_rise && settled) begin
            state   <= ST_COUNT;
            res_cnt <= '0;
            edges   <= '0;
          end
        end
        ST_COUNT: begin
          age     <= age_nxt;
          res_cnt <= res_cnt + RES_W'(1);
          if (slow_rise) edges <= edges + CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready   <= 1'b0;
      timeout <= 1'b0;
      result  <= '0;
    end else begin
      if (ev_clear)     ready <= 1'b0;
      else if (ev_done) ready <= 1'b1;

      if (ev_timeout)               timeout <= 1'b1;
      else if (ev_clear)            timeout <= 1'b0;
      else if (ev_done && run_cont) timeout <= 1'b0;

      if (ev_clear)     result <= '0;
      else if (ev_done) result <= res_cnt + RES_W'(1);
    end
  end
endmodule

// File: rtl/slow_cal_counter.sv
module slow_cal_counter #(
  parameter int CNT_W       = 15,
  parameter int RES_W       = 25,
  parameter int DIV_LOG2    = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_slow_rc,
  input  logic             clk_fast_rc,
  input  logic             clk_xtal32k,
  input  logic [1:0]       src_sel,
  input  logic [CNT_W-1:0] win_cycles,
  input  logic [RES_W-1:0] tmo_limit,
  input  logic             start_once,
  input  logic             start_cont,
  output logic             ready,
  output logic             timeout,
  output logic [RES_W-1:0] ref_count
);
  logic [1:0] ctl_s;
  logic       once_q;
  logic       arm_pulse;
  logic       cont_mode;
  logic       slow_rise;
  logic [1:0] sel_act;
  logic       ev_done;
  logic       ev_timeout;
  logic       ev_clear;

  cal_sync_2ff #(.W(2), .STAGES(SYNC_STAGES)) i_ctl_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({start_cont, start_once}),
    .q     (ctl_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) once_q <= 1'b0;
    else        once_q <= ctl_s[0];
  end

  assign arm_pulse = ctl_s[0] & ~once_q;
  assign cont_mode = ctl_s[1];

  cal_source_select #(.DIV_LOG2(DIV_LOG2), .SYNC_STAGES(SYNC_STAGES)) i_src (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (sel_act),
    .clk_slow_rc (clk_slow_rc),
    .clk_fast_rc (clk_fast_rc),
    .clk_xtal32k (clk_xtal32k),
    .slow_rise   (slow_rise)
  );

  cal_window_ctrl #(.CNT_W(CNT_W), .RES_W(RES_W), .SYNC_STAGES(SYNC_STAGES)) i_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_pulse  (arm_pulse),
    .cont_mode  (cont_mode),
    .slow_rise  (slow_rise),
    .sel_in     (src_sel),
    .cnt_in     (win_cycles),
    .thr_in     (tmo_limit),
    .sel_act    (sel_act),
    .ready      (ready),
    .timeout    (timeout),
    .result     (ref_count),
    .ev_done    (ev_done),
    .ev_timeout (ev_timeout),
    .ev_clear   (ev_clear)
  );
endmodule

// File: rtl/slow_cal_checker.sv
module slow_cal_checker #(
  parameter int RES_W = 25
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_done,
  input logic             ev_timeout,
  input logic             ev_clear,
  input logic             ready,
  input logic             timeout,
  input logic [RES_W-1:0] result
);
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_done && !ev_clear) |=> $stable(result));

  assert_done_sets_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> (ready && !timeout));

  assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clear && !ev_timeout) |=> (!ready && !timeout && (result == '0)));

  assert_timeout_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> timeout);

  assert_no_double_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_done && ev_timeout));
endmodule

bind slow_cal_counter slow_cal_checker #(.RES_W(RES_W)) i_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_done    (ev_done),
  .ev_timeout (ev_timeout),
  .ev_clear   (ev_clear),
  .ready      (ready),
  .timeout    (timeout),
  .result     (ref_count)
);

// File: tb/test_slow_cal_counter.sv
module test_slow_cal_counter;
  localparam int H_SLOW = 7;   // slow RC half period, reference cycles
  localparam int H_FAST = 1;   // fast RC half period
  localparam int H_XTAL = 5;   // crystal half period

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_slow_rc = 1'b0;
  logic        clk_fast_rc = 1'b0;
  logic        clk_xtal32k = 1'b0;
  logic [1:0]  src_sel = 2'd0;
  logic [14:0] win_cycles = 15'd3;
  logic [24:0] tmo_limit = '0;
  logic        start_once = 1'b0;
  logic        start_cont = 1'b1;
  logic        ready;
  logic        timeout;
  logic [24:0] ref_count;

  int n_chk = 0;
  int n_fail = 0;
  int ph_s = 0, ph_f = 0, ph_x = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    ph_s++; if (ph_s == H_SLOW) begin ph_s = 0; clk_slow_rc = ~clk_slow_rc; end
    ph_f++; if (ph_f == H_FAST) begin ph_f = 0; clk_fast_rc = ~clk_fast_rc; end
    ph_x++; if (ph_x == H_XTAL) begin ph_x = 0; clk_xtal32k = ~clk_xtal32k; end
  end

  slow_cal_counter i_slow_cal_counter (
    .clk(clk), .rst_n(rst_n), .clk_slow_rc(clk_slow_rc), .clk_fast_rc(clk_fast_rc),
    .clk_xtal32k(clk_xtal32k), .src_sel(src_sel), .win_cycles(win_cycles),
    .tmo_limit(tmo_limit), .start_once(start_once), .start_cont(start_cont),
    .ready(ready), .timeout(timeout), .ref_count(ref_count)
  );

  function automatic int src_period(input int sel);
    case (sel)
      0: return 2 * H_SLOW;
      1: return 2 * H_FAST * 32;
      default: return 2 * H_XTAL;
    endcase
  endfunction

  function automatic int window_len(input int sel, input int n);
    return n * src_period(sel);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wait_flag(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (ready || timeout) break;
    end
  endtask

  task automatic wait_ready(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (ready) break;
    end
  endtask

  task automatic run_once(input int sel, input int n, input int thr);
    @(negedge clk);
    start_once = 1'b0;
    src_sel    = 2'(sel);
    win_cycles = 15'(n);
    tmo_limit  = 25'(thr);
    repeat (4) @(negedge clk);
    start_once = 1'b1;
    repeat (6) @(negedge clk);
    check("R4 ready cleared at start", ready, 0);
    check("R4 result cleared at start", ref_count, 0);
    wait_flag(6000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int sel, n, thr, exp_len, hold;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    check("reset ready", ready, 0);
    check("reset timeout", timeout, 0);
    check("reset result", ref_count, 0);
    rst_n = 1'b1;

    // R6: continuous control held through reset, no start edge given
    wait_ready(1000);
    check("R6 ready after reset", ready, 1);
    check("R6 result", ref_count, window_len(0, 3));
    check("R6 timeout", timeout, 0);

    // R5: new length picked up by a later window with no restart
    @(negedge clk);
    win_cycles = 15'd5;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (ref_count == 25'(window_len(0, 5))) break;
    end
    check("R5 result follows new length", ref_count, window_len(0, 5));
    check("R5 ready stays", ready, 1);
    start_cont = 1'b0;
    repeat (20) @(negedge clk);

    // R1 / R3: one-shot on the crystal source
    run_once(2, 7, 0);
    check("R3 ready", ready, 1);
    check("R3 timeout", timeout, 0);
    check("R1 crystal result", ref_count, window_len(2, 7));
    hold = int'(ref_count);
    repeat (100) @(negedge clk);
    check("R10 result held", ref_count, hold);
    check("R3 single window", ready, 1);

    // R2: divided fast RC
    run_once(1, 2, 0);
    check("R2 ready", ready, 1);
    check("R2 fast RC result", ref_count, window_len(1, 2));

    // R7: limit shorter than the window
    run_once(0, 10, 30);
    check("R7 timeout", timeout, 1);
    check("R7 no ready", ready, 0);
    check("R7 result", ref_count, 0);

    // R4: restart clears timeout; R7 limit 0 disables
    run_once(0, 4, 0);
    check("R4 timeout cleared", timeout, 0);
    check("R7 zero limit ready", ready, 1);
    check("R1 slow RC result", ref_count, window_len(0, 4));

    // R8: illegal requests
    run_once(0, 0, 0);
    check("R8 zero window timeout", timeout, 1);
    repeat (50) @(negedge clk);
    check("R8 zero window no ready", ready, 0);
    run_once(2, 32767, 0);
    check("R8 max window timeout", timeout, 1);
    check("R8 max window no ready", ready, 0);
    run_once(3, 4, 0);
    check("R8 bad source timeout", timeout, 1);
    repeat (50) @(negedge clk);
    check("R8 bad source no ready", ready, 0);

    // R9: continuous timeout, then relaxed limit
    @(negedge clk);
    start_once = 1'b0;
    src_sel    = 2'd2;
    win_cycles = 15'd5;
    tmo_limit  = 25'd20;
    start_cont = 1'b1;
    repeat (80) @(negedge clk);
    check("R9 cont timeout", timeout, 1);
    check("R9 no ready yet", ready, 0);
    tmo_limit = 25'd0;
    wait_ready(2000);
    check("R9 ready after relax", ready, 1);
    check("R9 timeout cleared", timeout, 0);
    check("R9 result", ref_count, window_len(2, 5));
    start_cont = 1'b0;
    repeat (20) @(negedge clk);

    // Random one-shot runs: R1, R2, R7
    for (int k = 0; k < 14; k++) begin
      sel = int'($urandom % 3);
      n   = 1 + int'($urandom % 20);
      exp_len = window_len(sel, n);
      case ($urandom % 3)
        0: thr = 0;
        1: thr = exp_len + 3 * src_period(sel) + 40;
        default: thr = exp_len / 2;
      endcase
      run_once(sel, n, thr);
      if (thr != 0 && thr <= exp_len) begin
        check("R7 random timeout", timeout, 1);
        check("R7 random no ready", ready, 0);
      end else begin
        check("R1 R2 random ready", ready, 1);
        check("R1 R2 random result", ref_count, exp_len);
      end
    end

    finish_run();
  end
endmodule